// File: doc/BRIEF.md
# DMA Setup Register Gate

This block holds the programming registers for the transfer engine of a serial flash controller. It has four write-addressable registers: a control word, a flash-side start address, a memory-side start address and a byte count. Each address and count is masked as it is stored, so it is always word aligned and within range. A control write with the enable bit set makes the block issue a one-clock start strobe to the engine, and the latched parameters are presented alongside it.

Software must first claim the setup registers. It writes a fixed claim word to the control register, which sets both the request and grant flags. While the grant is held, address, count and control writes are accepted. The first accepted control write releases the grant automatically. A fixed release word drops the claim without starting anything. A write made without the grant is discarded and flagged with a one-cycle error strobe. A parameter removes the claim logic altogether. With it removed, every write is accepted and the two fixed words are ordinary control values.

The gate is a three-state machine:
- LOCKED: no grant held.
- OPEN: grant held.
- FIRE: the cycle that carries the start strobe; the grant is already gone.

The transitions are:
- claim: from any state to OPEN.
- release: from any state to LOCKED.
- accepted control write with enable clear: from OPEN to LOCKED.
- accepted control write with enable set: from OPEN to FIRE.
- strobe done: from FIRE to LOCKED when no claim arrives.

Top module: `dma_reg_gate`

## Requirements
- R1: After reset, all four registers read 0, the grant flags read 0, and neither `dma_start` nor `access_err` is high.
- R2: A control write whose value, after merging, equals 0xAEED0000 sets the request flag (bit 31) and the grant flag (bit 30). It leaves control bits 29:0 unchanged and starts nothing.
- R3: A control write whose merged value equals 0xDEEA0000 clears both flags, changes nothing else and raises no error.
- R4: Before a control value is compared or stored, the current request and grant flags are ORed into bits 31:30. So 0xAEED0000 written while the grant is held becomes 0xEEED0000 and is handled as an ordinary control write.
- R5: With the grant feature present and the grant clear, writes to any of the four registers (other than the two fixed words) are discarded. `access_err` is then high for exactly the one cycle after the write edge.
- R6: An accepted ordinary control write clears both flags, so a following address write is refused.
- R7: A stored count equals the written value AND 0x01FFFFFC.
- R8: A stored flash address equals the written value AND 0x0FFFFFFC. A stored memory address equals the written value AND 0x3FFFFFFC. An address write does not drop the grant.
- R9: An accepted control write with bit 0 (enable) clear stores bits 29:0 and gives no start strobe.
- R10: An accepted control write with bit 0 set stores bits 29:0. `dma_start` is then high for exactly the one cycle after the write edge, with `dma_flash_addr`, `dma_dram_addr` and `dma_len` holding the masked stored values.
- R11: With GRANT_EN=0, every write is accepted and never flagged. The fixed words are stored as ordinary control values (bits 31:30 read 0), and enable starts a transfer.
- R12: The select encoding is 0 control, 1 flash address, 2 memory address, 3 count. Control reads return {request, grant, stored bits 29:0}, and the other reads return the stored masked value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register selected for write |
| wr_data | input | 32 | Write value |
| rd_sel | input | 2 | Register selected for read |
| rd_data | output | 32 | Combinational read value |
| dma_start | output | 1 | One-cycle transfer start strobe |
| dma_ctrl | output | 32 | Stored control word (bits 31:30 zero) |
| dma_flash_addr | output | 32 | Masked flash start address |
| dma_dram_addr | output | 32 | Masked memory start address |
| dma_len | output | 32 | Masked byte count |
| access_err | output | 1 | One-cycle strobe for a refused write |

## Verification
The bench aims at the merge rule. It claims the registers and then claims again. A design that compares the raw value would keep the grant, where the correct design stores 0x2EED0000 and releases. The bench issues a second control write in the strobe cycle, which a design that releases late would accept as a second start. It also checks that address writes keep the grant, which a design that released on any write would break. It also sends the release word while already locked, which a design that checks the grant before the fixed words would flag as an error. All-ones values probe every mask edge. A second instance built without the claim logic confirms that the fixed words lose their meaning there.

// File: rtl/dma_gate_pkg.sv
package dma_gate_pkg;

    localparam int DW    = 32;
    localparam int SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_CTRL  = 2'd0,
        SEL_FLASH = 2'd1,
        SEL_DRAM  = 2'd2,
        SEL_LEN   = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_LOCKED = 2'd0,
        ST_OPEN   = 2'd1,
        ST_FIRE   = 2'd2
    } gate_state_e;

    localparam logic [DW-1:0] CLAIM_WORD   = 32'hAEED_0000;
    localparam logic [DW-1:0] RELEASE_WORD = 32'hDEEA_0000;
    localparam logic [DW-1:0] FLAG_BITS    = 32'hC000_0000;

endpackage

// File: rtl/dma_gate_fsm.sv
module dma_gate_fsm
    import dma_gate_pkg::*;
#(
    parameter bit GRANT_EN = 1'b1,
    parameter int EN_BIT   = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [DW-1:0]    wr_data,
    output logic [DW-1:0]    ctrl_merged,
    output logic             wr_accept,
    output logic             gate_open,
    output logic             start_pulse,
    output logic             err_pulse
);

    gate_state_e state_q, state_d;
    logic        err_q;
    logic        is_ctrl, allowed, cmd_claim, cmd_release, deny, launch;

    always_comb begin
        gate_open   = (state_q == ST_OPEN);
        allowed     = !GRANT_EN || gate_open;
        ctrl_merged = GRANT_EN ? (wr_data | (gate_open ? FLAG_BITS : '0)) : wr_data;
        is_ctrl     = wr_en && (wr_sel == SEL_CTRL);
        cmd_claim   = GRANT_EN && is_ctrl && (ctrl_merged == CLAIM_WORD);
        cmd_release = GRANT_EN && is_ctrl && (ctrl_merged == RELEASE_WORD);
        wr_accept   = wr_en && allowed && !cmd_claim && !cmd_release;
        deny        = wr_en && !allowed && !cmd_claim && !cmd_release;
        launch      = wr_accept && is_ctrl && ctrl_merged[EN_BIT];
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOCKED: begin
                if (cmd_claim)   state_d = ST_OPEN;
                else if (launch) state_d = ST_FIRE;
            end
            ST_OPEN: begin
                if (cmd_release)                 state_d = ST_LOCKED;
                else if (launch)                 state_d = ST_FIRE;
                else if (wr_accept && is_ctrl)   state_d = ST_LOCKED;
            end
            ST_FIRE: begin
                if (cmd_claim)   state_d = ST_OPEN;
                else if (launch) state_d = ST_FIRE;
                else             state_d = ST_LOCKED;
            end
            default: state_d = ST_LOCKED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LOCKED;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            err_q   <= deny;
        end
    end

    always_comb begin
        start_pulse = (state_q == ST_FIRE);
        err_pulse   = err_q;
    end

endmodule

// File: rtl/dma_gate_regs.sv
module dma_gate_regs
    import dma_gate_pkg::*;
#(
    parameter logic [DW-1:0] FLASH_MASK = 32'h0FFF_FFFC,
    parameter logic [DW-1:0] DRAM_MASK  = 32'h3FFF_FFFC,
    parameter logic [DW-1:0] LEN_MASK   = 32'h01FF_FFFC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_accept,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [DW-1:0]    wr_data,
    input  logic [DW-3:0]    ctrl_low,
    output logic [DW-3:0]    ctrl_q,
    output logic [DW-1:0]    flash_q,
    output logic [DW-1:0]    dram_q,
    output logic [DW-1:0]    len_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            flash_q <= '0;
            dram_q  <= '0;
            len_q   <= '0;
        end else if (wr_accept) begin
            unique case (reg_sel_e'(wr_sel))
                SEL_CTRL:  ctrl_q  <= ctrl_low;
                SEL_FLASH: flash_q <= wr_data & FLASH_MASK;
                SEL_DRAM:  dram_q  <= wr_data & DRAM_MASK;
                SEL_LEN:   len_q   <= wr_data & LEN_MASK;
                default:   ctrl_q  <= ctrl_q;
            endcase
        end
    end

endmodule

// File: rtl/dma_reg_gate.sv
module dma_reg_gate
    import dma_gate_pkg::*;
#(
    parameter bit            GRANT_EN   = 1'b1,
    parameter int            EN_BIT     = 0,
    parameter logic [31:0]   FLASH_MASK = 32'h0FFF_FFFC,
    parameter logic [31:0]   DRAM_MASK  = 32'h3FFF_FFFC,
    parameter logic [31:0]   LEN_MASK   = 32'h01FF_FFFC
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [31:0] wr_data,
    input  logic [1:0]  rd_sel,
    output logic [31:0] rd_data,
    output logic        dma_start,
    output logic [31:0] dma_ctrl,
    output logic [31:0] dma_flash_addr,
    output logic [31:0] dma_dram_addr,
    output logic [31:0] dma_len,
    output logic        access_err
);

    logic [DW-1:0] ctrl_merged;
    logic [DW-3:0] ctrl_q;
    logic          wr_accept;
    logic          gate_open;

    dma_gate_fsm #(
        .GRANT_EN (GRANT_EN),
        .EN_BIT   (EN_BIT)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_sel      (wr_sel),
        .wr_data     (wr_data),
        .ctrl_merged (ctrl_merged),
        .wr_accept   (wr_accept),
        .gate_open   (gate_open),
        .start_pulse (dma_start),
        .err_pulse   (access_err)
    );

    dma_gate_regs #(
        .FLASH_MASK (FLASH_MASK),
        .DRAM_MASK  (DRAM_MASK),
        .LEN_MASK   (LEN_MASK)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_accept (wr_accept),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .ctrl_low  (ctrl_merged[DW-3:0]),
        .ctrl_q    (ctrl_q),
        .flash_q   (dma_flash_addr),
        .dram_q    (dma_dram_addr),
        .len_q     (dma_len)
    );

    assign dma_ctrl = {2'b00, ctrl_q};

    always_comb begin
        unique case (reg_sel_e'(rd_sel))
            SEL_CTRL:  rd_data = {gate_open, gate_open, ctrl_q};
            SEL_FLASH: rd_data = dma_flash_addr;
            SEL_DRAM:  rd_data = dma_dram_addr;
            SEL_LEN:   rd_data = dma_len;
            default:   rd_data = '0;
        endcase
    end

endmodule

// File: rtl/dma_reg_gate_chk.sv
module dma_reg_gate_chk #(
    parameter bit GRANT_EN = 1'b1
) (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [1:0]  wr_sel,
    input logic        wr_en_bit,
    input logic        gate_open,
    input logic        dma_start,
    input logic        access_err,
    input logic [31:0] dma_flash_addr,
    input logic [31:0] dma_len
);

    // R10: the strobe never lasts two cycles
    a_r10_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        dma_start |=> !dma_start);

    // R10: a strobe follows only a control write with enable set
    a_r10_start_cause: assert property (@(posedge clk) disable iff (!rst_n)
        dma_start |-> $past(wr_en && wr_sel == 2'd0 && wr_en_bit));

    // R5: an error strobe follows only a write
    a_r5_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        access_err |-> $past(wr_en));

    // R5: a write while locked never starts a transfer
    a_r5_locked_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (GRANT_EN && wr_en && !gate_open) |=> !dma_start);

    // R11: without the claim logic nothing is ever refused
    a_r11_no_err_free: assert property (@(posedge clk) disable iff (!rst_n)
        !GRANT_EN |-> !access_err);

    // R8: addresses change only after a write
    a_r8_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> ($stable(dma_flash_addr) && $stable(dma_len)));

    // R10 / R5: start and error strobes are exclusive
    a_r10_start_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(dma_start && access_err));

endmodule

bind dma_reg_gate dma_reg_gate_chk #(.GRANT_EN(GRANT_EN)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_en          (wr_en),
    .wr_sel         (wr_sel),
    .wr_en_bit      (wr_data[EN_BIT]),
    .gate_open      (gate_open),
    .dma_start      (dma_start),
    .access_err     (access_err),
    .dma_flash_addr (dma_flash_addr),
    .dma_len        (dma_len)
);

// File: tb/dma_reg_gate_tb.sv
`timescale 1ns/100ps
module dma_reg_gate_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_sel = 2'd0;
    logic [31:0] rd_data, dma_ctrl, dma_flash_addr, dma_dram_addr, dma_len;
    logic        dma_start, access_err;

    logic        f_wr_en = 1'b0;
    logic [1:0]  f_wr_sel = 2'd0;
    logic [31:0] f_wr_data = '0;
    logic [1:0]  f_rd_sel = 2'd0;
    logic [31:0] f_rd_data, f_ctrl, f_flash, f_dram, f_len;
    logic        f_start, f_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state
    bit          m_gnt;
    logic [31:0] m_ctrl, m_fa, m_da, m_len;
    bit          exp_start, exp_err;

    always #4 clk = ~clk;

    dma_reg_gate u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .dma_start(dma_start), .dma_ctrl(dma_ctrl),
        .dma_flash_addr(dma_flash_addr), .dma_dram_addr(dma_dram_addr),
        .dma_len(dma_len), .access_err(access_err)
    );

    dma_reg_gate #(.GRANT_EN(1'b0)) u_free (
        .clk(clk), .rst_n(rst_n), .wr_en(f_wr_en), .wr_sel(f_wr_sel), .wr_data(f_wr_data),
        .rd_sel(f_rd_sel), .rd_data(f_rd_data), .dma_start(f_start), .dma_ctrl(f_ctrl),
        .dma_flash_addr(f_flash), .dma_dram_addr(f_dram), .dma_len(f_len),
        .access_err(f_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // model of one write at a clock edge
    task automatic model_write(input logic [1:0] sel, input logic [31:0] d);
        logic [31:0] merged;
        exp_start = 1'b0;
        exp_err   = 1'b0;
        merged = d | (m_gnt ? 32'hC000_0000 : 32'h0);
        if (sel == 2'd0 && merged == 32'hAEED_0000) m_gnt = 1'b1;
        else if (sel == 2'd0 && merged == 32'hDEEA_0000) m_gnt = 1'b0;
        else if (!m_gnt) exp_err = 1'b1;
        else begin
            case (sel)
                2'd0: begin
                    m_ctrl    = merged & 32'h3FFF_FFFF;
                    exp_start = merged[0];
                    m_gnt     = 1'b0;
                end
                2'd1: m_fa  = d & 32'h0FFF_FFFC;
                2'd2: m_da  = d & 32'h3FFF_FFFC;
                default: m_len = d & 32'h01FF_FFFC;
            endcase
        end
    endtask

    task automatic compare(input string req);
        chk({req, " start"}, {31'b0, dma_start}, {31'b0, exp_start});
        chk({req, " err"}, {31'b0, access_err}, {31'b0, exp_err});
        chk({req, " out flash"}, dma_flash_addr, m_fa);
        chk({req, " out dram"}, dma_dram_addr, m_da);
        chk({req, " out len"}, dma_len, m_len);
        for (int s = 0; s < 4; s++) begin
            rd_sel = 2'(s);
            #0.5;
            case (s)
                0: chk({req, " R12 rd ctrl"}, rd_data, {m_gnt, m_gnt, m_ctrl[29:0]});
                1: chk({req, " R12 rd flash"}, rd_data, m_fa);
                2: chk({req, " R12 rd dram"}, rd_data, m_da);
                default: chk({req, " R12 rd len"}, rd_data, m_len);
            endcase
        end
    endtask

    task automatic wr(input string req, input logic [1:0] sel, input logic [31:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(posedge clk);
        model_write(sel, d);
        @(negedge clk);
        wr_en = 1'b0;
        compare(req);
    endtask

    task automatic idle(input string req);
        @(negedge clk);
        exp_start = 1'b0;
        exp_err   = 1'b0;
        compare(req);
    endtask

    task automatic fwr(input logic [1:0] sel, input logic [31:0] d);
        f_wr_en = 1'b1; f_wr_sel = sel; f_wr_data = d;
        @(negedge clk);
        f_wr_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        m_gnt = 0; m_ctrl = 0; m_fa = 0; m_da = 0; m_len = 0;
        exp_start = 0; exp_err = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare("R1 reset");

        wr("R5 locked len", 2'd3, 32'h0000_0100);
        wr("R5 locked ctrl", 2'd0, 32'h0000_0001);
        idle("R5 err one cycle");
        wr("R2 claim", 2'd0, 32'hAEED_0000);
        wr("R7 len mask", 2'd3, 32'hFFFF_FFFF);
        wr("R8 flash mask", 2'd1, 32'hFFFF_FFFF);
        wr("R8 dram mask", 2'd2, 32'hFFFF_FFFF);
        wr("R9 ctrl no enable", 2'd0, 32'h0000_0100);
        wr("R6 after release", 2'd1, 32'h0000_0040);
        wr("R2 claim again", 2'd0, 32'hAEED_0000);
        wr("R8 flash", 2'd1, 32'h1234_5677);
        wr("R8 dram", 2'd2, 32'h8765_4321);
        wr("R7 len", 2'd3, 32'h0000_1003);
        wr("R10 start", 2'd0, 32'h0000_0F01);
        wr("R10 write in strobe cycle", 2'd0, 32'h0000_0003);
        idle("R10 strobe over");
        wr("R2 claim 3", 2'd0, 32'hAEED_0000);
        wr("R3 release", 2'd0, 32'hDEEA_0000);
        wr("R3 locked after release", 2'd3, 32'h0000_0800);
        wr("R3 release while locked", 2'd0, 32'hDEEA_0000);
        wr("R2 claim 4", 2'd0, 32'hAEED_0000);
        wr("R4 merged claim is ordinary", 2'd0, 32'hAEED_0000);
        wr("R4 grant gone", 2'd2, 32'h0000_1000);
        idle("R1 quiet");

        // instance without the claim logic
        fwr(2'd3, 32'hFFFF_FFFF);
        fwr(2'd0, 32'hAEED_0000);
        f_rd_sel = 2'd0; #0.5;
        chk("R11 claim word stored plainly", f_rd_data, 32'h2EED_0000);
        f_rd_sel = 2'd3; #0.5;
        chk("R11 len accepted", f_rd_data, 32'h01FF_FFFC);
        chk("R11 no err", {31'b0, f_err}, 32'h0);
        fwr(2'd0, 32'h0000_0005);
        chk("R11 start", {31'b0, f_start}, 32'h1);
        chk("R11 ctrl", f_ctrl, 32'h0000_0005);
        @(negedge clk);
        chk("R11 start ends", {31'b0, f_start}, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule